// File: doc/BRIEF.md
# Row/Column Decoded Single-Bit Static RAM

This block is a small static memory of single-bit cells laid out as a square matrix. Each address is split into two fields. The low field picks a row line and the high field picks a column line. The one cell where the active row meets the active column is the cell that gets written or read. A chip select, active low, and a read/write select line set the mode. A read returns the stored bit on a true output and on a complemented output.

Real pads would tri-state the outputs. Here a pair of output-enable flags stands in for them. The flags are raised only during a read. Writes take effect on the rising clock edge. Reads follow the current address with no clock delay.

The one-hot row and column select vectors are brought out as observation ports. An asynchronous active-low reset clears every cell.

Top module: `xy_bit_ram`

## Requirements
- R1: The row decoder is driven by address bits [1:0] and the column decoder by address bits [3:2]. `rowHot` has bit `addr[1:0]` set and `colHot` has bit `addr[3:2]` set.
- R2: In every mode each of `rowHot` and `colHot` has exactly one bit high and the other three low.
- R3: With `chipSelN`=0 and `readSel`=0, the rising clock edge stores `dataIn` into the addressed cell, and no other cell changes.
- R4: With `chipSelN`=0 and `readSel`=1, `dataOut` equals the addressed cell's stored bit and `dataOutN` its complement, both within the same cycle and with no clock edge needed. Both `trueEn` and `compEn` are 1.
- R5: With `chipSelN`=1 (storage mode), `trueEn` and `compEn` are 0. No cell changes on any clock edge, whatever the values of `addr`, `dataIn` and `readSel`.
- R6: In write mode (`chipSelN`=0, `readSel`=0), `trueEn` and `compEn` are 0.
- R7: Whenever the enables are 0, `dataOut` and `dataOutN` are both parked at 0.
- R8: Driving `rstN` low clears all 16 cells to 0 at once, without waiting for a clock edge.
- R9: All 16 addresses reach distinct cells, so any pattern written across the array reads back bit for bit.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes occur on its rising edge |
| rstN | input | 1 | Asynchronous active-low clear of all cells |
| chipSelN | input | 1 | Chip select, active low; high selects storage mode |
| readSel | input | 1 | 1 = read, 0 = write, when selected |
| addr | input | 4 | Cell address; [1:0] row, [3:2] column |
| dataIn | input | 1 | Bit to store in write mode |
| dataOut | output | 1 | Stored bit (true form) |
| dataOutN | output | 1 | Stored bit (complemented form) |
| trueEn | output | 1 | Output-enable flag for `dataOut` |
| compEn | output | 1 | Output-enable flag for `dataOutN` |
| rowHot | output | 4 | One-hot row select |
| colHot | output | 4 | One-hot column select |

## Verification
The bench builds the block with its default two row bits and two column bits. This keeps the array at 16 cells, so every row/column crossing can be written and read back exhaustively. At that size the bench can also prove that a single write disturbs no neighbour, and that the decoder vectors track every address value. The same size makes it cheap to hold a full expected image of the array and compare it after storage-mode noise and after a mid-cycle reset.

// File: rtl/xy_bit_ram_pkg.sv
package xy_bit_ram_pkg;

  typedef struct packed {
    logic writeStb;
    logic readStb;
  } ramStrobe_t;

endpackage

// File: rtl/xy_onehot_dec.sv
module xy_onehot_dec #(
  parameter int IN_W = 2,
  localparam int OUT_N = 1 << IN_W
) (
  input  logic [IN_W-1:0]  sel,
  output logic [OUT_N-1:0] hot
);

  for (genvar k = 0; k < OUT_N; k++) begin : g_line
    assign hot[k] = (sel == IN_W'(k));
  end

endmodule

// File: rtl/xy_bit_ram_ctrl.sv
module xy_bit_ram_ctrl
  import xy_bit_ram_pkg::*;
(
  input  logic       chipSelN,
  input  logic       readSel,
  output ramStrobe_t strobe
);

  always_comb begin
    strobe = '0;
    if (!chipSelN) begin
      strobe.writeStb = !readSel;
      strobe.readStb  = readSel;
    end
  end

endmodule

// File: rtl/xy_bit_ram_dp.sv
module xy_bit_ram_dp
  import xy_bit_ram_pkg::*;
#(
  parameter int ROW_BITS = 2,
  parameter int COL_BITS = 2,
  localparam int ADDR_W = ROW_BITS + COL_BITS,
  localparam int ROWS = 1 << ROW_BITS,
  localparam int COLS = 1 << COL_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  ramStrobe_t        strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic              dataIn,
  output logic              dataOut,
  output logic              dataOutN,
  output logic              trueEn,
  output logic              compEn,
  output logic [ROWS-1:0]   rowHot,
  output logic [COLS-1:0]   colHot
);

  logic [ROWS-1:0][COLS-1:0] cellBit;
  logic [ROWS-1:0][COLS-1:0] cellHit;
  logic                      readBit;

  xy_onehot_dec #(.IN_W(ROW_BITS)) rowDec (
    .sel(addr[ROW_BITS-1:0]),
    .hot(rowHot)
  );

  xy_onehot_dec #(.IN_W(COL_BITS)) colDec (
    .sel(addr[ADDR_W-1:ROW_BITS]),
    .hot(colHot)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          cellBit[r][c] <= 1'b0;
        else if (strobe.writeStb && rowHot[r] && colHot[c])
          cellBit[r][c] <= dataIn;
      end
      assign cellHit[r][c] = rowHot[r] & colHot[c] & cellBit[r][c];
    end
  end

  assign readBit  = |cellHit;
  assign trueEn   = strobe.readStb;
  assign compEn   = strobe.readStb;
  assign dataOut  = strobe.readStb & readBit;
  assign dataOutN = strobe.readStb & ~readBit;

endmodule

// File: rtl/xy_bit_ram.sv
module xy_bit_ram
  import xy_bit_ram_pkg::*;
#(
  parameter int ROW_BITS = 2,
  parameter int COL_BITS = 2,
  localparam int ADDR_W = ROW_BITS + COL_BITS,
  localparam int ROWS = 1 << ROW_BITS,
  localparam int COLS = 1 << COL_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipSelN,
  input  logic              readSel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              dataIn,
  output logic              dataOut,
  output logic              dataOutN,
  output logic              trueEn,
  output logic              compEn,
  output logic [ROWS-1:0]   rowHot,
  output logic [COLS-1:0]   colHot
);

  ramStrobe_t strobe;

  xy_bit_ram_ctrl ctrl (
    .chipSelN(chipSelN),
    .readSel (readSel),
    .strobe  (strobe)
  );

  xy_bit_ram_dp #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .addr    (addr),
    .dataIn  (dataIn),
    .dataOut (dataOut),
    .dataOutN(dataOutN),
    .trueEn  (trueEn),
    .compEn  (compEn),
    .rowHot  (rowHot),
    .colHot  (colHot)
  );

endmodule

// File: rtl/xy_bit_ram_chk.sv
module xy_bit_ram_chk #(
  parameter int ROW_BITS = 2,
  parameter int COL_BITS = 2,
  localparam int ADDR_W = ROW_BITS + COL_BITS,
  localparam int ROWS = 1 << ROW_BITS,
  localparam int COLS = 1 << COL_BITS
) (
  input logic              clk,
  input logic              rstN,
  input logic              chipSelN,
  input logic              readSel,
  input logic [ADDR_W-1:0] addr,
  input logic              dataIn,
  input logic              dataOut,
  input logic              dataOutN,
  input logic              trueEn,
  input logic              compEn,
  input logic [ROWS-1:0]   rowHot,
  input logic [COLS-1:0]   colHot
);

  // R2
  row_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(rowHot) == 1);

  // R2
  col_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(colHot) == 1);

  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    chipSelN |-> (!trueEn && !compEn));

  // R6
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!chipSelN && !readSel) |-> (!trueEn && !compEn));

  // R4
  read_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!chipSelN && readSel) |-> (trueEn && compEn && (dataOutN == !dataOut)));

  // R7
  park_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !trueEn |-> (!dataOut && !dataOutN));

  // R3
  write_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!chipSelN && !readSel) |=>
      (!(!chipSelN && readSel && addr == $past(addr)) || dataOut == $past(dataIn)));

endmodule

bind xy_bit_ram xy_bit_ram_chk #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) chk (
  .clk(clk), .rstN(rstN), .chipSelN(chipSelN), .readSel(readSel), .addr(addr),
  .dataIn(dataIn), .dataOut(dataOut), .dataOutN(dataOutN), .trueEn(trueEn),
  .compEn(compEn), .rowHot(rowHot), .colHot(colHot)
);

// File: tb/xy_bit_ram_test.sv
`timescale 1ns/1ps
module xy_bit_ram_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       chipSelN = 1'b1;
  logic       readSel = 1'b1;
  logic [3:0] addr = '0;
  logic       dataIn = 1'b0;
  logic       dataOut, dataOutN, trueEn, compEn;
  logic [3:0] rowHot, colHot;

  int  checks = 0;
  int  fails = 0;
  bit  done = 1'b0;
  logic [15:0] model = '0;

  always #2.5 clk = ~clk;

  xy_bit_ram uut (
    .clk(clk), .rstN(rstN), .chipSelN(chipSelN), .readSel(readSel),
    .addr(addr), .dataIn(dataIn), .dataOut(dataOut), .dataOutN(dataOutN),
    .trueEn(trueEn), .compEn(compEn), .rowHot(rowHot), .colHot(colHot)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doWrite(input logic [3:0] a, input logic d);
    @(negedge clk);
    chipSelN = 1'b0; readSel = 1'b0; addr = a; dataIn = d;
    #1;
    check("R6 write enables", {trueEn, compEn}, 8'h0);
    check("R7 write parked", {dataOut, dataOutN}, 8'h0);
    @(posedge clk);
    model[a] = d;
  endtask

  task automatic readCheck(input logic [3:0] a, input string req);
    @(negedge clk);
    chipSelN = 1'b0; readSel = 1'b1; addr = a;
    #1;
    check(req, {trueEn, compEn, dataOut, dataOutN},
          {2'b11, model[a], ~model[a]});
  endtask

  task automatic readAll(input string req);
    for (int i = 0; i < 16; i++) readCheck(4'(i), req);
  endtask

  task automatic testReset();
    @(negedge clk);
    #1;
    check("R5 idle enables at reset", {trueEn, compEn}, 8'h0);
    rstN = 1'b1;
    model = '0;
    readAll("R8 cleared after reset");
  endtask

  task automatic testDecode();
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      addr = 4'(i);
      chipSelN = (i % 3 == 0) ? 1'b1 : 1'b0;
      readSel = i[0];
      #1;
      check("R1 row select", {4'h0, rowHot}, {4'h0, 4'(1 << i[1:0])});
      check("R1 col select", {4'h0, colHot}, {4'h0, 4'(1 << i[3:2])});
      check("R2 onehot count", 8'($countones(rowHot) + $countones(colHot)), 8'd2);
    end
  endtask

  task automatic testSingleWrite();
    doWrite(4'd9, 1'b1);
    readAll("R3 single write isolated");
    doWrite(4'd9, 1'b0);
    readCheck(4'd9, "R3 overwrite with zero");
  endtask

  task automatic testPatterns();
    for (int i = 0; i < 16; i++) doWrite(4'(i), 1'(i[0] ^ i[2]));
    readAll("R9 checker pattern");
    for (int i = 0; i < 16; i++) doWrite(4'(i), 1'((i * 7 + 3) % 5 < 2));
    readAll("R9 scrambled pattern");
    for (int i = 15; i >= 0; i--) doWrite(4'(i), ~model[i]);
    readAll("R4 inverted pattern");
  endtask

  task automatic testStorageIgnore();
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      chipSelN = 1'b1; readSel = i[1]; addr = 4'(i); dataIn = ~model[i];
      #1;
      check("R5 storage enables", {trueEn, compEn}, 8'h0);
      check("R7 storage parked", {dataOut, dataOutN}, 8'h0);
    end
    readAll("R5 storage left array intact");
  endtask

  task automatic testAsyncReset();
    for (int i = 0; i < 16; i++) doWrite(4'(i), 1'b1);
    @(negedge clk);
    chipSelN = 1'b0; readSel = 1'b1; addr = 4'd6;
    #1;
    check("R4 read before clear", {dataOut, dataOutN}, 8'h2);
    rstN = 1'b0;
    #0.5;
    check("R8 async clear no edge", {dataOut, dataOutN}, 8'h1);
    model = '0;
    @(negedge clk);
    rstN = 1'b1;
    readAll("R8 all cells cleared");
  endtask

  initial begin
    testReset();
    testDecode();
    testSingleWrite();
    testPatterns();
    testStorageIgnore();
    testAsyncReset();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule